// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from thirteen sources and presents one of them to the processor at a time. The sources are one nonmaskable input, five maskable external pins, and seven internal sources: three timers, two DMA channels, the serial port and a watchdog. Each maskable source has a mask bit and a 3-bit priority. Among the eligible requests, the one with the best priority is shown on `irq_o`, and `vec_o` carries its type code.

The processor acknowledges with `ack_i`. This marks the winning source as in service. A later end-of-interrupt write names a source and releases it. With nesting off, nothing maskable is presented while any source is in service. With nesting on, only a strictly better priority can preempt the routine in progress. Two mode bits change how the external pins are used. In cascade mode, a cascaded external controller supplies the vector for an external-pin winner and receives an acknowledge strobe. In slave mode, an outside master owns the external lines, so the pins take no part in arbitration.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every maskable source is masked, every priority is 7 and all mode bits are clear. `irq_o` is low and `vec_o` is 8'h00 whenever the nonmaskable input is low.
- R2: The nonmaskable input (source 0) is presented whenever it is high. It ignores masks, in-service state and mode, and gives vector 8'h02. Acknowledging it sets no in-service bit.
- R3: Source indices are as follows: external pins 0..4 are sources 1..5, timers 0..2 are 6..8, DMA 0..1 are 9..10, serial is 11 and watchdog is 12. Source k (1..12) gives vector 8'h20+k. `vec_o` is 8'h00 while `irq_o` is low.
- R4: A lower priority value wins. Between equal values, the lower source index wins.
- R5: A source whose mask bit is set is never presented.
- R6: A register write at address k (1..12) loads data bit 3 as that source's mask and bits 2:0 as its priority. A write at address 16 loads the mode: bit 0 is nesting, bit 1 is cascade and bit 2 is slave. The write takes effect from the next clock edge.
- R7: `ack_i` high while `irq_o` is high sets the in-service bit of the presented maskable source. An end-of-interrupt write with `eoi_src_i` = k clears bit k.
- R8: With nesting off, no maskable source is presented while any in-service bit is set.
- R9: With nesting on, a maskable source is presented only if its priority value is strictly lower than the best priority value among the in-service sources.
- R10: In cascade mode, when an external pin wins, `vec_o` equals `cas_vec_i`, and `cas_ack_o` follows `ack_i`. For internal winners, the vector and `cas_ack_o` are unaffected.
- R11: In slave mode, requests on the five external pins are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Nonmaskable request |
| ext_req_i | input | 5 | External maskable request pins |
| tmr_req_i | input | 3 | Timer requests |
| dma_req_i | input | 2 | DMA channel requests |
| ser_req_i | input | 1 | Serial port request |
| wdt_req_i | input | 1 | Watchdog request |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 5 | Register address |
| cfg_wdata_i | input | 4 | Register write data |
| ack_i | input | 1 | Interrupt acknowledge from processor |
| eoi_we_i | input | 1 | End-of-interrupt write strobe |
| eoi_src_i | input | 4 | Source index released by end-of-interrupt |
| cas_vec_i | input | 8 | Vector supplied by cascaded external controller |
| irq_o | output | 1 | Interrupt request to processor |
| vec_o | output | 8 | Type code of presented source |
| cas_ack_o | output | 1 | Acknowledge strobe to cascaded controller |

## Verification
The assertions assume that requests are level-held and that the processor raises `ack_i` only while `irq_o` is high. They also assume that an end-of-interrupt names a source in the range 0..12 and does not name the source being acknowledged in the same cycle. The stimulus changes requests, acknowledges, register writes and end-of-interrupt writes only on falling edges, and it pulses each strobe for exactly one clock. It always acknowledges a presented request before releasing it. Register writes and end-of-interrupt writes are never issued in the same cycle as an acknowledge.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int NSRC     = 13;
  localparam int PW       = 3;
  localparam int IW       = $clog2(NSRC);
  localparam int VW       = 8;
  localparam int CDW      = 4;
  localparam int CAW      = 5;
  localparam int EXT_LO   = 1;
  localparam int EXT_N    = 5;
  localparam int MODE_ADR = 16;
  localparam logic [VW-1:0] NMI_VEC  = 8'h02;
  localparam logic [VW-1:0] VEC_BASE = 8'h20;

  typedef struct packed {
    logic slave;
    logic cascade;
    logic nest;
  } mode_t;

  function automatic logic [VW-1:0] vec_of(input logic [IW-1:0] idx);
    return (idx == '0) ? NMI_VEC : VEC_BASE + VW'(idx);
  endfunction

  function automatic logic is_ext(input logic [IW-1:0] idx);
    return (idx >= IW'(EXT_LO)) && (idx < IW'(EXT_LO + EXT_N));
  endfunction

  // a beats b: better priority value, or same value and lower index
  function automatic logic beats(input logic [PW:0] pa, input logic [IW-1:0] ia,
                                 input logic [PW:0] pb, input logic [IW-1:0] ib);
    return (pa < pb) || ((pa == pb) && (ia < ib));
  endfunction
endpackage

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
  import nic_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [CAW-1:0]      addr,
  input  logic [CDW-1:0]      wdata,
  output logic [NSRC-1:0]     mask_q,
  output logic [NSRC*PW-1:0]  prio_q,
  output mode_t               mode_q
);
  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      if (g == 0) begin : g_nmi
        assign mask_q[g]         = 1'b0;
        assign prio_q[g*PW +: PW] = '0;
      end else begin : g_mask
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            mask_q[g]          <= 1'b1;
            prio_q[g*PW +: PW] <= '1;
          end else if (we && addr == CAW'(g)) begin
            mask_q[g]          <= wdata[PW];
            prio_q[g*PW +: PW] <= wdata[PW-1:0];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                mode_q <= '0;
    else if (we && addr == CAW'(MODE_ADR))     mode_q <= wdata[2:0];
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
(
  input  logic [NSRC-1:0]    req,
  input  logic [NSRC-1:0]    mask_q,
  input  logic [NSRC*PW-1:0] prio_q,
  input  logic [NSRC-1:0]    isr_q,
  input  mode_t              mode_q,
  output logic [NSRC-1:0]    elig,
  output logic               win_valid,
  output logic [IW-1:0]      win_idx
);
  logic [PW:0]   top_isr;
  logic [PW:0]   best_p;
  logic          isr_busy;

  assign isr_busy = |isr_q;

  always_comb begin
    top_isr = {1'b1, {PW{1'b0}}};
    for (int i = 0; i < NSRC; i++) begin
      if (isr_q[i] && ({1'b0, prio_q[i*PW +: PW]} < top_isr))
        top_isr = {1'b0, prio_q[i*PW +: PW]};
    end
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      elig[i] = (i != 0) && req[i] && !mask_q[i]
              && !(mode_q.slave && is_ext(IW'(i)))
              && (mode_q.nest ? ({1'b0, prio_q[i*PW +: PW]} < top_isr) : !isr_busy);
    end
  end

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    best_p    = '1;
    for (int i = 1; i < NSRC; i++) begin
      if (elig[i] && (!win_valid || beats({1'b0, prio_q[i*PW +: PW]}, IW'(i), best_p, win_idx))) begin
        win_valid = 1'b1;
        win_idx   = IW'(i);
        best_p    = {1'b0, prio_q[i*PW +: PW]};
      end
    end
    if (req[0]) begin
      win_valid = 1'b1;
      win_idx   = '0;
    end
  end
endmodule

// File: rtl/nic_isr.sv
module nic_isr
  import nic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [IW-1:0]   set_idx,
  input  logic            clr_en,
  input  logic [IW-1:0]   clr_idx,
  output logic [NSRC-1:0] isr_q
);
  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 isr_q[g] <= 1'b0;
        else if (set_en && set_idx == IW'(g))       isr_q[g] <= 1'b1;
        else if (clr_en && clr_idx == IW'(g))       isr_q[g] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nmi_i,
  input  logic [4:0] ext_req_i,
  input  logic [2:0] tmr_req_i,
  input  logic [1:0] dma_req_i,
  input  logic       ser_req_i,
  input  logic       wdt_req_i,
  input  logic       cfg_we_i,
  input  logic [4:0] cfg_addr_i,
  input  logic [3:0] cfg_wdata_i,
  input  logic       ack_i,
  input  logic       eoi_we_i,
  input  logic [3:0] eoi_src_i,
  input  logic [7:0] cas_vec_i,
  output logic       irq_o,
  output logic [7:0] vec_o,
  output logic       cas_ack_o
);
  logic [NSRC-1:0]    req;
  logic [NSRC-1:0]    mask_q;
  logic [NSRC*PW-1:0] prio_q;
  mode_t              mode_q;
  logic [NSRC-1:0]    isr_q;
  logic [NSRC-1:0]    elig;
  logic               win_valid;
  logic [IW-1:0]      win_idx;
  logic               ack_fire;
  logic               ext_win;

  assign req = {wdt_req_i, ser_req_i, dma_req_i, tmr_req_i, ext_req_i, nmi_i};

  nic_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we_i), .addr(cfg_addr_i), .wdata(cfg_wdata_i),
    .mask_q(mask_q), .prio_q(prio_q), .mode_q(mode_q)
  );

  nic_arbiter u_arb (
    .req(req), .mask_q(mask_q), .prio_q(prio_q), .isr_q(isr_q), .mode_q(mode_q),
    .elig(elig), .win_valid(win_valid), .win_idx(win_idx)
  );

  assign ack_fire = ack_i && win_valid && (win_idx != '0);
  assign ext_win  = win_valid && is_ext(win_idx);

  nic_isr u_isr (
    .clk(clk), .rst_n(rst_n), .set_en(ack_fire), .set_idx(win_idx),
    .clr_en(eoi_we_i), .clr_idx(eoi_src_i), .isr_q(isr_q)
  );

  assign irq_o     = win_valid;
  assign vec_o     = !win_valid ? '0 : (mode_q.cascade && ext_win) ? cas_vec_i : vec_of(win_idx);
  assign cas_ack_o = ack_i && mode_q.cascade && ext_win;
endmodule

// File: rtl/nic_chk.sv
module nic_chk
  import nic_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            nmi_i,
  input logic            ack_i,
  input logic            irq_o,
  input logic [7:0]      vec_o,
  input logic            cas_ack_o,
  input logic [IW-1:0]   win_idx,
  input logic [NSRC-1:0] isr_q,
  input logic [NSRC-1:0] mask_q,
  input logic            m_nest,
  input logic            m_cas,
  input logic            m_slave
);
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_i |-> (irq_o && vec_o == NMI_VEC));                                       // R2
  AST_NMI_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && win_idx == '0 && isr_q == '0) |=> (isr_q == '0));          // R2
  AST_NO_NEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_nest && isr_q != '0 && !nmi_i) |-> !irq_o);                               // R8
  AST_ACK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && win_idx != '0) |=> isr_q[$past(win_idx)]);                 // R7
  AST_MASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && win_idx != '0) |-> !mask_q[win_idx]);                               // R5
  AST_SLAVE_NO_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (m_slave && irq_o) |-> !is_ext(win_idx));                                     // R11
  AST_CAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cas_ack_o |-> (ack_i && m_cas && irq_o));                                     // R10
  AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_o == '0));                                                    // R3
endmodule

bind nest_irq_ctrl nic_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .ack_i(ack_i), .irq_o(irq_o),
  .vec_o(vec_o), .cas_ack_o(cas_ack_o), .win_idx(win_idx), .isr_q(isr_q),
  .mask_q(mask_q), .m_nest(mode_q.nest), .m_cas(mode_q.cascade), .m_slave(mode_q.slave)
);

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_i = 0; logic [4:0] ext_req_i = 0; logic [2:0] tmr_req_i = 0;
  logic [1:0] dma_req_i = 0; logic ser_req_i = 0; logic wdt_req_i = 0;
  logic cfg_we_i = 0; logic [4:0] cfg_addr_i = 0; logic [3:0] cfg_wdata_i = 0;
  logic ack_i = 0; logic eoi_we_i = 0; logic [3:0] eoi_src_i = 0;
  logic [7:0] cas_vec_i = 0;
  logic irq_o; logic [7:0] vec_o; logic cas_ack_o;
  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  nest_irq_ctrl dut_i (.*);

  // {request[12:0] (bit0 = nmi), expected irq, expected vector}
  // priorities programmed as (k*3)%8: 1:3 2:6 3:1 4:4 5:7 6:2 7:5 8:0 9:3 10:6 11:1 12:4
  localparam logic [21:0] VECS [10] = '{
    {13'h0020, 1'b1, 8'h25},  // R3 single pin 4
    {13'h0202, 1'b1, 8'h21},  // R4 tie at 3, lower index
    {13'h0808, 1'b1, 8'h23},  // R4 tie at 1
    {13'h1FFE, 1'b1, 8'h28},  // R4 best value 0 among all
    {13'h1404, 1'b1, 8'h2C},  // R4 watchdog beats dma
    {13'h1010, 1'b1, 8'h24},  // R4 tie at 4
    {13'h0101, 1'b1, 8'h02},  // R2 nmi over best maskable
    {13'h00C0, 1'b1, 8'h26},  // R6 programmed order
    {13'h0000, 1'b0, 8'h00},  // R3 idle vector
    {13'h0820, 1'b1, 8'h2B}   // R3 serial
  };

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_req(input logic [12:0] r);
    @(negedge clk);
    {wdt_req_i, ser_req_i, dma_req_i, tmr_req_i, ext_req_i, nmi_i} = r;
    #1;
  endtask

  task automatic cfg(input logic [4:0] a, input logic [3:0] d);
    @(negedge clk); cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk); cfg_we_i = 0; #1;
  endtask

  task automatic ack_pulse(output logic cas_seen);
    @(negedge clk); ack_i = 1; #1; cas_seen = cas_ack_o;
    @(negedge clk); ack_i = 0; #1;
  endtask

  task automatic eoi(input logic [3:0] s);
    @(negedge clk); eoi_we_i = 1; eoi_src_i = s;
    @(negedge clk); eoi_we_i = 0; #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic cs;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    set_req(13'h1FFE);
    chk("R1 reset masked", {irq_o, vec_o}, 9'h000);
    chk("R1 cas idle", {8'h00, cas_ack_o}, 9'h000);
    set_req(13'h0000);
    for (int k = 1; k < 13; k++) cfg(5'(k), {1'b0, 3'((k * 3) % 8)});   // R6
    for (int i = 0; i < 10; i++) begin
      set_req(VECS[i][21:9]);
      chk("R4 table", {irq_o, vec_o}, VECS[i][8:0]);
    end
    // R5 mask
    cfg(5'd8, 4'b1000);
    set_req(13'h0120);
    chk("R5 masked skipped", {irq_o, vec_o}, {1'b1, 8'h25});
    cfg(5'd8, 4'b0000);
    chk("R6 unmask restores", {irq_o, vec_o}, {1'b1, 8'h28});
    // R7 / R8 nest off
    set_req(13'h0040);
    chk("R7 present", {irq_o, vec_o}, {1'b1, 8'h26});
    ack_pulse(cs);
    set_req(13'h0140);
    chk("R8 blocked", {irq_o, vec_o}, 9'h000);
    set_req(13'h0141);
    chk("R2 bypass isr", {irq_o, vec_o}, {1'b1, 8'h02});
    set_req(13'h0140);
    eoi(4'd6);
    chk("R7 eoi releases", {irq_o, vec_o}, {1'b1, 8'h28});
    set_req(13'h0001);
    ack_pulse(cs);
    set_req(13'h0040);
    chk("R2 no isr on nmi", {irq_o, vec_o}, {1'b1, 8'h26});
    // R9 nesting
    cfg(5'd16, 4'b0001);
    ack_pulse(cs);
    set_req(13'h00D0);
    chk("R9 not higher", {irq_o, vec_o}, 9'h000);
    set_req(13'h01D0);
    chk("R9 preempt", {irq_o, vec_o}, {1'b1, 8'h28});
    ack_pulse(cs);
    set_req(13'h0008);
    chk("R9 under top", {irq_o, vec_o}, 9'h000);
    eoi(4'd8);
    chk("R9 after eoi", {irq_o, vec_o}, {1'b1, 8'h23});
    eoi(4'd6);
    set_req(13'h0000);
    // R10 cascade
    cfg(5'd16, 4'b0010);
    cas_vec_i = 8'h77;
    set_req(13'h0010);
    chk("R10 cascade vec", {irq_o, vec_o}, {1'b1, 8'h77});
    chk("R10 no strobe", {8'h00, cas_ack_o}, 9'h000);
    ack_pulse(cs);
    chk("R10 strobe", {8'h00, cs}, 9'h001);
    eoi(4'd4);
    set_req(13'h0040);
    chk("R10 internal vec", {irq_o, vec_o}, {1'b1, 8'h26});
    ack_pulse(cs);
    chk("R10 internal strobe", {8'h00, cs}, 9'h000);
    eoi(4'd6);
    // R11 slave
    cfg(5'd16, 4'b0100);
    set_req(13'h003E);
    chk("R11 pins ignored", {irq_o, vec_o}, 9'h000);
    set_req(13'h00BE);
    chk("R11 internal served", {irq_o, vec_o}, {1'b1, 8'h27});
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule